// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the station-management side of a two-wire PHY management link. It makes the management clock MDC from the system clock. On a one-cycle request it runs a single register read or register write frame on the bidirectional data line. The pin itself is a tri-state pad with a pull-up outside this block. The controller drives that pad through an output-enable and output-data pair, and it watches the pad level on a separate input.

Each frame has 64 MDC periods. It begins with a preamble of 32 ones, followed by the start pattern, the opcode, the PHY address, the register address, a two-bit turnaround and 16 data bits. All fields go out most significant bit first. The controller changes the line only on the falling edge of MDC, so the value is settled around the rising edge where the PHY samples it. On a read, the controller releases the line at the turnaround and keeps it released until the frame ends. It samples the PHY's data on the rising edges of MDC. When the frame finishes, it returns the read data and a one-cycle done pulse.

The MDC half-period is derived at elaboration time from the system clock frequency and the highest MDC frequency allowed. The divider is rounded up, so MDC never runs faster than that limit.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc, mdio_oe, busy and done are 0, and rd_data is 0.
- R2: While busy, every MDC high phase and every MDC low phase lasts exactly HALF system cycles, where HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ)). While idle, MDC is held low.
- R3: At the 64 MDC rising edges of a frame the line carries 32 ones, then the start bits 0,1. On the clock after acceptance, the line is already driven with 1 and MDC is still low.
- R4: The two opcode bits after the start bits are 1,0 for a read (req_read=1) and 0,1 for a write.
- R5: The 5-bit PHY address and then the 5-bit register address follow the opcode, each MSB first.
- R6: On a write, the line is driven for all 64 bits. The turnaround is 1,0, followed by req_wdata MSB first.
- R7: On a read, mdio_oe is 1 for bits 0 to 45 and 0 from bit 46 (the first turnaround bit) through the end of the frame.
- R8: On a read, mdio_in is sampled on the MDC rising edges of bits 48 to 63. It is assembled MSB first and appears on rd_data in the cycle done is high. A write leaves rd_data unchanged.
- R9: busy rises on the clock after a request is accepted (req_valid while not busy) and falls together with done. A request while busy is ignored and starts no later frame.
- R10: done is a single-cycle pulse, once per frame. After it, mdio_oe stays 0 until the next request.
- R11: While a frame is in progress, mdio_oe and the driven mdio_out change only on clocks where MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Pad output enable |
| mdio_out | output | 1 | Pad output value |
| mdio_in | input | 1 | Pad level |

## Verification
The bench builds the block with CLK_HZ = 100,000,000 and MDC_MAX_HZ = 12,500,000. This gives a four-cycle half period and a frame of 512 system cycles. At this size, every MDC phase length and every line change in several complete frames can be checked cycle by cycle. A PHY model in the bench shares the line with the master and answers read turnarounds. This exercises the hand-over of the line and the capture of the returned data. The divider arithmetic that yields HALF is the same code that produces the 2.5 MHz default.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;

    // System cycles per MDC half period, rounded up so MDC never exceeds the limit
    function automatic int mdc_half(input int clk_hz, input int mdc_hz);
        int h;
        h = (clk_hz + 2 * mdc_hz - 1) / (2 * mdc_hz);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t q, d;
    logic tick;

    assign tick     = run && (q.cnt == LAST);
    assign rise_stb = tick && !q.mdc;
    assign fall_stb = tick && q.mdc;
    assign mdc      = q.mdc;

    always_comb begin
        d = q;
        if (!run) begin
            d = '0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_master_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_oe,
    output logic        mdio_out
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [31:0]      word;   // bits after the preamble, MSB sent first
        logic             oe;
        logic             out;
        logic [15:0]      shin;
        logic [15:0]      rdata;
    } seq_t;

    seq_t q, d;
    logic [IDX_W-1:0] nidx;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        nidx   = q.idx + 1'b1;
        if (!q.busy) begin
            if (req_valid) begin
                d.busy = 1'b1;
                d.rd   = req_read;
                d.idx  = '0;
                d.word = {START_PAT, req_read ? OP_READ : OP_WRITE,
                          req_phy, req_reg, TA_WRITE,
                          req_read ? 16'h0000 : req_wdata};
                d.oe   = 1'b1;
                d.out  = 1'b1;
            end
        end else begin
            if (rise_stb && q.rd && (q.idx >= DATA_IDX))
                d.shin = {q.shin[14:0], mdio_in};
            if (fall_stb) begin
                if (q.idx == LAST_IDX) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.oe   = 1'b0;
                    d.out  = 1'b1;
                    if (q.rd) d.rdata = q.shin;
                end else begin
                    d.idx = nidx;
                    d.out = nidx[IDX_W-1] ? q.word[~nidx[4:0]] : 1'b1;
                    d.oe  = !(q.rd && (nidx >= TA_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign rd_data  = q.rdata;
    assign mdio_oe  = q.oe;
    assign mdio_out = q.out;

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_oe,
    output logic        mdio_out,
    input  logic        mdio_in
);
    localparam int HALF = mdio_master_pkg::mdc_half(CLK_HZ, MDC_MAX_HZ);

    logic rise_stb;
    logic fall_stb;

    mdio_mdc_gen #(.HALF(HALF)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdio_oe   (mdio_oe),
        .mdio_out  (mdio_out)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_oe,
    input logic mdio_out
);
    assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_first_bit_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_out && !mdc));

    assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_oe_only_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    assert_line_moves_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) &&
         (!$stable(mdio_oe) || (mdio_oe && !$stable(mdio_out)))) |-> $fell(mdc));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .mdio_out (mdio_out)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int HALF = 4;  // ceil(100e6 / (2 * 12.5e6))

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_oe, mdio_out;
    logic [15:0] rd_data;
    logic        phy_drv = 1'b1;
    logic        mdio_line;

    assign mdio_line = mdio_oe ? mdio_out : phy_drv;

    always #5 clk = ~clk;

    mdio_master #(.CLK_HZ(100_000_000), .MDC_MAX_HZ(12_500_000)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_oe(mdio_oe), .mdio_out(mdio_out), .mdio_in(mdio_line)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // PHY-side capture and response
    logic [63:0] cap_line, cap_oe;
    logic [15:0] phy_word = '0;
    int rise_cnt = 0;

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_line[63 - rise_cnt] = mdio_line;
            cap_oe[63 - rise_cnt]   = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt <= 63) phy_drv = phy_word[63 - rise_cnt];
        else                                  phy_drv = 1'b1;
    end

    // Phase length and line-change monitor
    logic pm = 1'b0, pb = 1'b0, po = 1'b0, pout = 1'b0;
    int hi_len = 0, lo_len = 0, per_err = 0, chg_err = 0, done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) begin
                hi_len = 0;
                lo_len = 0;
            end else begin
                if (mdc != pm) begin
                    if (pm) begin
                        if (hi_len != HALF) per_err++;
                        hi_len = 0;
                    end else begin
                        if (lo_len != HALF) per_err++;
                        lo_len = 0;
                    end
                end
                if (mdc) hi_len++;
                else     lo_len++;
            end
            if (pb && busy && (mdio_oe != po || (mdio_oe && mdio_out != pout)) && !(pm && !mdc))
                chg_err++;
            if (done) done_cnt++;
            pm = mdc; pb = busy; po = mdio_oe; pout = mdio_out;
        end
    end

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, wd};
    endfunction

    task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pd, input bit poke,
                           input logic [15:0] prev_rd);
        logic [63:0] ef, mask, eoe;
        int k;
        phy_word = pd; rise_cnt = 0; per_err = 0; chg_err = 0; done_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_phy = pa; req_reg = ra; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
            if (poke && k == 100) begin
                req_valid = 1'b1; req_read = ~rd; req_phy = ~pa; req_reg = ~ra; req_wdata = ~wd;
            end
            if (poke && k == 101) req_valid = 1'b0;
        end
        chk(done == 1'b1, "R10 done reached", 64'(done), 64'd1);
        chk(busy == 1'b0, "R9 busy low with done", 64'(busy), 64'd0);
        ef   = exp_frame(rd, pa, ra, wd);
        mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        eoe  = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        chk((cap_line & mask) == (ef & mask), "R3 R4 R5 R6 frame bits", cap_line & mask, ef & mask);
        chk(cap_oe == eoe, "R6 R7 output enable per bit", cap_oe, eoe);
        chk(rise_cnt == 64, "R3 rising edge count", 64'(rise_cnt), 64'd64);
        chk(per_err == 0, "R2 MDC phase length", 64'(per_err), 64'd0);
        chk(chg_err == 0, "R11 line change off falling edge", 64'(chg_err), 64'd0);
        if (rd) chk(rd_data == pd, "R8 read data", 64'(rd_data), 64'(pd));
        else    chk(rd_data == prev_rd, "R8 write keeps rd_data", 64'(rd_data), 64'(prev_rd));
        @(negedge clk);
        chk(done == 1'b0 && mdio_oe == 1'b0, "R10 done pulse and release", {done, mdio_oe}, 64'd0);
        chk(done_cnt == 1, "R10 one done per frame", 64'(done_cnt), 64'd1);
    endtask

    // {read, phy, reg, wdata, phy reply}
    localparam logic [42:0] VECS [0:5] = '{
        {1'b0, 5'h00, 5'h00, 16'hA5C3, 16'h0000},
        {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h8001},
        {1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000},
        {1'b1, 5'h01, 5'h02, 16'h0000, 16'h0000},
        {1'b0, 5'h1F, 5'h10, 16'h0001, 16'h0000},
        {1'b1, 5'h0A, 5'h15, 16'h0000, 16'h1234}
    };

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] last_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mdc, mdio_oe, busy, done} == 4'b0, "R1 reset controls", {mdc, mdio_oe, busy, done}, 64'd0);
        chk(rd_data == 16'h0, "R1 reset rd_data", 64'(rd_data), 64'd0);
        last_rd = 16'h0;
        for (int i = 0; i < 6; i++) begin
            run_txn(VECS[i][42], VECS[i][41:37], VECS[i][36:32], VECS[i][31:16], VECS[i][15:0], 1'b0, last_rd);
            if (VECS[i][42]) last_rd = VECS[i][15:0];
        end
        // Request while busy must be ignored and start nothing afterwards (R9)
        run_txn(1'b0, 5'h0C, 5'h03, 16'h5A5A, 16'h0000, 1'b1, last_rd);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0 && mdc == 1'b0, "R9 no frame from ignored request", {busy, mdc}, 64'd0);
        chk(rise_cnt == 64, "R9 no extra MDC edges", 64'(rise_cnt), 64'd64);
        // Back-to-back read right after a write
        run_txn(1'b1, 5'h00, 5'h1E, 16'h0000, 16'hC3A5, 1'b1, last_rd);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule